// File: doc/BRIEF.md
# Scan Launch-Capture Sequencer for Delay Test

This block steers a plain mux-scan chain, one with no hold latches, through a two-pattern delay test for transition and path-delay faults. It first shifts the initial state vector into the chain with slow clock pulses while the first primary-input vector is applied. It then issues two rated-speed pulses: a launch pulse, which creates the second vector, and a capture pulse one rated period later. Finally it shifts the response out with slow pulses. Everything runs on one fast system clock. Chain pulses are requested as one-cycle enables, and each enable carries a flag that says whether the clock gate should pass a slow or a rated pulse. The gated edge falls at the end of the enabled cycle.

Two launch styles are offered. In shift-launch mode the launch pulse is one more scan shift, so the scan enable stays high through the launch cycle and drops on the launch edge. In capture-launch mode the second vector is the circuit's functional response to the first, so the scan enable is already low for the settle period, the launch pulse and the capture pulse. The mode is latched when a run starts.

Top module: `scan_delay_seq`

## Requirements
- R1: While reset is held, and afterwards with no start, every output is low.
- R2: The cycle after start is sampled, a load phase of CHAIN_LEN*SLOW_DIV cycles begins. In this phase scan_en is high and clk_pulse is high with clk_rated low in every SLOW_DIV-th cycle, which gives exactly CHAIN_LEN slow pulses.
- R3: A settle phase of SLOW_DIV cycles follows the load phase. It has no pulse, and pi_sel is 0 throughout it.
- R4: In shift-launch mode (los_mode=1 at start), scan_en stays high through the settle and launch cycles and is low from the cycle after launch.
- R5: In capture-launch mode (los_mode=0 at start), scan_en is low from the first settle cycle through the capture cycle.
- R6: The launch cycle directly follows the settle phase. The capture cycle comes exactly RATED_DIV cycles after the launch cycle. Both cycles assert clk_pulse and clk_rated, and each has its own one-cycle strobe (launch_stb, capture_stb).
- R7: pi_sel is 1 (second input vector) from the cycle after launch through the capture cycle, and 0 at all other times.
- R8: After capture, an unload phase of CHAIN_LEN*SLOW_DIV cycles repeats the load pulse pattern with scan_en high.
- R9: done is high for the single cycle after unload. busy is high from the first load cycle through the done cycle and low after it.
- R10: los_mode is used only in the cycle where start is accepted, and start has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run when idle |
| los_mode | input | 1 | 1 = shift-launch, 0 = capture-launch |
| scan_en | output | 1 | Scan enable to the chain (1 = shift) |
| clk_pulse | output | 1 | Enable one chain clock pulse this cycle |
| clk_rated | output | 1 | Pulse is at rated speed (0 = slow) |
| pi_sel | output | 1 | Primary-input vector select (0 = first, 1 = second) |
| launch_stb | output | 1 | One-cycle strobe on the launch pulse |
| capture_stb | output | 1 | One-cycle strobe on the capture pulse |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
The sequence is run in shift-launch mode and in capture-launch mode. Comparing the two runs shows whether the scan-enable drop falls on the launch edge or ahead of the settle phase. A further pair of runs toggles los_mode and pulses start in the middle of the sequence. This exposes any design that re-reads the mode after start, or restarts while busy. The bench uses a rated divide larger than one, so a waiting gap lies between launch and capture, and an off-by-one in the rated spacing or in the input-vector switch point shows as a cycle mismatch.

// File: rtl/scan_delay_pkg.sv
package scan_delay_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD   = 3'd1,
    PH_SETTLE = 3'd2,
    PH_LAUNCH = 3'd3,
    PH_WAIT   = 3'd4,
    PH_CAPT   = 3'd5,
    PH_UNLOAD = 3'd6,
    PH_DONE   = 3'd7
  } phase_e;

  typedef struct packed {
    logic busy;
    logic done;
    logic scan_en;
    logic pulse;
    logic rated;
    logic pi_sel;
    logic launch;
    logic capture;
  } ctl_t;

  // cycles spent on one full chain shift
  function automatic int shift_cycles(int chain_len, int slow_div);
    return chain_len * slow_div;
  endfunction

  // counter width able to hold 0..limit-1
  function automatic int cnt_width(int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/sds_counter.sv
module sds_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = scan_delay_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign last = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sds_decode.sv
module sds_decode
  import scan_delay_pkg::*;
(
  input  phase_e ph,
  input  logic   mode_q,
  input  logic   slow_last,
  output ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    case (ph)
      PH_LOAD, PH_UNLOAD: begin
        ctl.busy    = 1'b1;
        ctl.scan_en = 1'b1;
        ctl.pulse   = slow_last;
      end
      PH_SETTLE: begin
        ctl.busy    = 1'b1;
        ctl.scan_en = mode_q;
      end
      PH_LAUNCH: begin
        ctl.busy    = 1'b1;
        ctl.scan_en = mode_q;
        ctl.pulse   = 1'b1;
        ctl.rated   = 1'b1;
        ctl.launch  = 1'b1;
      end
      PH_WAIT: begin
        ctl.busy    = 1'b1;
        ctl.pi_sel  = 1'b1;
      end
      PH_CAPT: begin
        ctl.busy    = 1'b1;
        ctl.pi_sel  = 1'b1;
        ctl.pulse   = 1'b1;
        ctl.rated   = 1'b1;
        ctl.capture = 1'b1;
      end
      PH_DONE: begin
        ctl.busy    = 1'b1;
        ctl.done    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/scan_delay_seq.sv
module scan_delay_seq
  import scan_delay_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int SLOW_DIV  = 4,
  parameter int RATED_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic los_mode,
  output logic scan_en,
  output logic clk_pulse,
  output logic clk_rated,
  output logic pi_sel,
  output logic launch_stb,
  output logic capture_stb,
  output logic busy,
  output logic done
);
  localparam bit HAS_GAP = (RATED_DIV > 1);

  phase_e ph, ph_n;
  logic   mode_q;
  logic   slow_last, bit_last, gap_last;
  logic   shifting, phase_chg;
  ctl_t   ctl;

  assign shifting  = (ph == PH_LOAD) || (ph == PH_UNLOAD);
  assign phase_chg = (ph_n != ph);

  // slow period divider, runs during load, settle and unload
  sds_counter #(.LIMIT(SLOW_DIV)) u_slow (
    .clk(clk), .rst_n(rst_n), .clr(phase_chg),
    .en(shifting || (ph == PH_SETTLE)), .last(slow_last)
  );

  // counts slow pulses across one chain length
  sds_counter #(.LIMIT(CHAIN_LEN)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr(phase_chg),
    .en(shifting && slow_last), .last(bit_last)
  );

  generate
    if (HAS_GAP) begin : g_gap
      sds_counter #(.LIMIT(RATED_DIV - 1)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(phase_chg),
        .en(ph == PH_WAIT), .last(gap_last)
      );
    end else begin : g_nogap
      assign gap_last = 1'b1;
    end
  endgenerate

  always_comb begin
    ph_n = ph;
    case (ph)
      PH_IDLE:   if (start) ph_n = PH_LOAD;
      PH_LOAD:   if (slow_last && bit_last) ph_n = PH_SETTLE;
      PH_SETTLE: if (slow_last) ph_n = PH_LAUNCH;
      PH_LAUNCH: ph_n = HAS_GAP ? PH_WAIT : PH_CAPT;
      PH_WAIT:   if (gap_last) ph_n = PH_CAPT;
      PH_CAPT:   ph_n = PH_UNLOAD;
      PH_UNLOAD: if (slow_last && bit_last) ph_n = PH_DONE;
      PH_DONE:   ph_n = PH_IDLE;
      default:   ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      mode_q <= 1'b0;
    end else begin
      ph <= ph_n;
      if (ph == PH_IDLE && start) mode_q <= los_mode;
    end
  end

  sds_decode u_dec (
    .ph(ph), .mode_q(mode_q), .slow_last(slow_last), .ctl(ctl)
  );

  assign scan_en     = ctl.scan_en;
  assign clk_pulse   = ctl.pulse;
  assign clk_rated   = ctl.rated;
  assign pi_sel      = ctl.pi_sel;
  assign launch_stb  = ctl.launch;
  assign capture_stb = ctl.capture;
  assign busy        = ctl.busy;
  assign done        = ctl.done;
endmodule

// File: rtl/sds_chk.sv
module sds_chk #(
  parameter int RATED_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic scan_en,
  input logic clk_pulse,
  input logic clk_rated,
  input logic pi_sel,
  input logic launch_stb,
  input logic capture_stb,
  input logic busy,
  input logic done,
  input logic mode_q
);
  logic [15:0] since_launch;

  always_ff @(posedge clk) begin
    if (!rst_n)            since_launch <= '0;
    else if (launch_stb)   since_launch <= 16'd1;
    else if (capture_stb)  since_launch <= '0;
    else if (since_launch != 0) since_launch <= since_launch + 16'd1;
  end

  // R2
  slow_pulse_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_pulse && !clk_rated) |-> scan_en);

  // R4
  los_launch_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb && mode_q) |-> scan_en);

  // R5
  loc_launch_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb && !mode_q) |-> !scan_en);

  // R4
  after_launch_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |=> !scan_en);

  // R6
  rated_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb || capture_stb) |-> (clk_pulse && clk_rated));

  // R6
  capture_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |-> (since_launch == 16'(RATED_DIV)));

  // R7
  pi_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb |-> !pi_sel) and (capture_stb |-> pi_sel));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_stb, capture_stb, done}));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind scan_delay_seq sds_chk #(.RATED_DIV(RATED_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .clk_pulse(clk_pulse),
  .clk_rated(clk_rated), .pi_sel(pi_sel), .launch_stb(launch_stb),
  .capture_stb(capture_stb), .busy(busy), .done(done), .mode_q(mode_q)
);

// File: tb/sim_scan_delay_seq.sv
`timescale 1ns/1ps
module sim_scan_delay_seq;
  localparam int CH = 6;
  localparam int SD = 3;
  localparam int RD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic los_mode = 1'b0;
  logic scan_en, clk_pulse, clk_rated, pi_sel;
  logic launch_stb, capture_stb, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] q_val[$];
  string      q_req[$];

  always #10 clk = ~clk;

  scan_delay_seq #(.CHAIN_LEN(CH), .SLOW_DIV(SD), .RATED_DIV(RD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .los_mode(los_mode),
    .scan_en(scan_en), .clk_pulse(clk_pulse), .clk_rated(clk_rated),
    .pi_sel(pi_sel), .launch_stb(launch_stb), .capture_stb(capture_stb),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] observed();
    return {busy, done, scan_en, clk_pulse, clk_rated, pi_sel, launch_stb, capture_stb};
  endfunction

  // expected {busy,done,scan,pulse,rated,pi,launch,capture} for cycle k after start
  function automatic logic [7:0] expect_at(int k, bit los);
    int shift_len = CH * SD;
    int t_launch  = shift_len + SD + 1;
    int t_capt    = t_launch + RD;
    int t_done    = t_capt + shift_len + 1;
    if (k <= shift_len)
      return {1'b1, 1'b0, 1'b1, (k % SD == 0), 4'b0000};
    if (k < t_launch)
      return {1'b1, 1'b0, los, 5'b00000};
    if (k == t_launch)
      return {1'b1, 1'b0, los, 5'b11010};
    if (k < t_capt)
      return 8'b1000_0100;
    if (k == t_capt)
      return 8'b1001_1101;
    if (k < t_done)
      return {1'b1, 1'b0, 1'b1, ((k - t_capt) % SD == 0), 4'b0000};
    if (k == t_done)
      return 8'b1100_0000;
    return 8'b0000_0000;
  endfunction

  function automatic string req_at(int k, bit los, bit disturb);
    int shift_len = CH * SD;
    int t_launch  = shift_len + SD + 1;
    int t_capt    = t_launch + RD;
    string s;
    if (k <= shift_len)        s = "R2";
    else if (k < t_launch)     s = los ? "R3/R4" : "R3/R5";
    else if (k == t_launch)    s = los ? "R6/R4" : "R6/R5";
    else if (k < t_capt)       s = "R7";
    else if (k == t_capt)      s = "R6/R7";
    else if (k <= t_capt + shift_len) s = "R8";
    else                       s = "R9";
    if (disturb) s = {s, "/R10"};
    return s;
  endfunction

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (q_val.size() > 0) begin
      logic [7:0] e;
      string r;
      e = q_val.pop_front();
      r = q_req.pop_front();
      checks++;
      if (observed() !== e) begin
        errors++;
        $display("FAIL %s got=%b exp=%b (busy,done,scan,pulse,rated,pi,launch,capt)",
                 r, observed(), e);
      end
    end
  end

  task automatic run_test(bit los, bit disturb);
    int total = 2 * CH * SD + SD + RD + 3;
    int n = 0;
    @(negedge clk);
    start    = 1'b1;
    los_mode = los;
    @(posedge clk);
    #1;
    for (int k = 1; k <= total; k++) begin
      q_val.push_back(expect_at(k, los));
      q_req.push_back(req_at(k, los, disturb));
    end
    @(negedge clk);
    start = 1'b0;
    while (q_val.size() != 0) begin
      @(negedge clk);
      n++;
      if (disturb) begin
        los_mode = ~los_mode;
        start    = (q_val.size() > 5) && (n % 4 == 1);
      end
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== 8'h00) begin
      errors++;
      $display("FAIL R1 in reset got=%b exp=%b", observed(), 8'h00);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== 8'h00) begin
      errors++;
      $display("FAIL R1 idle after reset got=%b exp=%b", observed(), 8'h00);
    end
    run_test(1'b1, 1'b0);
    run_test(1'b0, 1'b0);
    run_test(1'b0, 1'b1);
    run_test(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    checks++;
    if (observed() !== 8'h00) begin
      errors++;
      $display("FAIL R10 idle after disturbed runs got=%b exp=%b", observed(), 8'h00);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired got=busy exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule